// File: doc/BRIEF.md
# CPU PLL Rate Switch Sequencer

This block retunes the PLL that feeds a CPU core when software or boot logic asks for a new core rate. A request carries the target rate in MHz on `rate_mhz` together with a one-cycle `start` pulse. The sequencer looks up the PLL multiplier and dividers and the bus divider settings for that rate, and builds the encoded control words. It then walks a fixed, safe sequence of masked register writes on a single-strobe write port. The sequence first moves the PLL output to slow mode and powers the PLL down. It then loads the new PLL settings, pauses, and releases power-down. Next it loads the new clock-select dividers and pauses again. Only after that does it switch the PLL back to normal mode.

Every register word uses the masked-write form. The upper 16 bits are a write-enable mask and the lower 16 bits hold the data, so that each bit `n+16` enables bit `n`. The two pauses are plain cycle counts, set by parameters. `busy` is high for the whole sequence. The sequence ends with a one-cycle `done` pulse. If the request names an unsupported rate, the block answers with a one-cycle `error` pulse and issues no write.

Top module: `cpu_pll_retuner`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `wr_valid` are all low.
- R2: Only 1608, 1008 and 600 are accepted on `rate_mhz`. Any other value at `start` in idle gives an `error` pulse in the next cycle, with `busy` staying low and no `wr_valid` strobe.
- R3: An accepted request issues exactly eight writes, one per address, in this order: mode (0x040), power (0x00C), PLL word A (0x000), PLL word B (0x004), power (0x00C), select 0 (0x044), select 1 (0x048), mode (0x040). The first strobe comes in the cycle after `start`.
- R4: The mode word for slow is 0x00030000 and for normal is 0x00030001 (field bits 1:0: slow=0, normal=1). The power word for power-down is 0x00020002 and for power-up is 0x00020000 (bit 1 = powered down).
- R5: PLL word A is 0x3F0F0000 | (NR-1)<<8 | (NO-1), and PLL word B is 0xFFFF0000 | (NF-1). The settings are: 1608 uses NR=1, NF=67, NO=1; 1008 uses NR=1, NF=42, NO=1; 600 uses NR=1, NF=50, NO=2. This gives A/B = 3F0F0000/FFFF0042, 3F0F0000/FFFF0029 and 3F0F0001/FFFF0031.
- R6: Select word 0 is 0x3FDF0000 | (core_div-1)<<9 | peri_code<<6 | (aclk_div-1). Bit 8 is cleared to select the PLL. peri_code is log2(peri_div)-1. The core divider is 1 at all rates. peri_div is 8 at 1608 and 1008 and 4 at 600. aclk_div is 4 at 1608 and 3 at 1008 and 600. This gives 3FDF0083, 3FDF0082 and 3FDF0042.
- R7: Select word 1 is 0xF3070000 | axi_code | log2(hclk)<<8 | log2(pclk)<<12 | log2(bridge)<<14. axi_code maps 1,2,3,4,8 to 0,1,2,3,4. The core AXI divider is 4 at 1608, 3 at 1008 and 4 at 600. hclk=2, pclk=4 and bridge=2 at every rate. This gives F3076103, F3076102 and F3076103.
- R8: Each `wr_valid` strobe lasts one cycle, and no further strobe comes before `wr_ack`. Outside the two pauses, the next strobe comes in the cycle right after the cycle in which `wr_ack` is high.
- R9: The power-up strobe comes exactly LOCK_CYCLES+1 cycles after the cycle in which PLL word B is acknowledged.
- R10: The final mode strobe comes exactly SETTLE_CYCLES+1 cycles after the cycle in which select word 1 is acknowledged.
- R11: `busy` is high from the cycle after an accepted `start` through the final acknowledge. `done` pulses for one cycle right after the final acknowledge, and `busy` is low in that cycle.
- R12: A `start` while `busy` is high is ignored. The running sequence keeps its words, and no `error` or extra `done` results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request pulse |
| rate_mhz | input | RATE_W | Requested core rate in MHz |
| wr_valid | output | 1 | One-cycle write strobe |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 32 | Masked write word |
| wr_ack | input | 1 | Write acknowledge from the register file |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed pulse |
| error | output | 1 | Unsupported rate pulse |

## Verification
The assertions assume that `wr_ack` is raised only after a strobe and only once per strobe. They also assume that `start` is a pulse and not a level held high. The bench answers each strobe with a single-cycle acknowledge, one to three cycles later. It sends `start` only as one-cycle pulses, so the ignored-start case meets a busy sequencer and never an idle one. Shortened pause counts keep the wait windows measurable.

// File: rtl/cpu_pll_retuner.sv
module cpu_pll_retuner #(
  parameter int ADDR_W        = 12,
  parameter int RATE_W        = 11,
  parameter int LOCK_CYCLES   = 5000,
  parameter int SETTLE_CYCLES = 50000,
  parameter logic [ADDR_W-1:0] A_MODE = 'h040,
  parameter logic [ADDR_W-1:0] A_PWR  = 'h00C,
  parameter logic [ADDR_W-1:0] A_PLLA = 'h000,
  parameter logic [ADDR_W-1:0] A_PLLB = 'h004,
  parameter logic [ADDR_W-1:0] A_SEL0 = 'h044,
  parameter logic [ADDR_W-1:0] A_SEL1 = 'h048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] rate_mhz,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  input  logic              wr_ack,
  output logic              busy,
  output logic              done,
  output logic              error
);

  localparam int MAXW  = (LOCK_CYCLES > SETTLE_CYCLES) ? LOCK_CYCLES : SETTLE_CYCLES;
  localparam int CNT_W = $clog2(MAXW + 1);
  localparam logic [CNT_W-1:0] LOCK_LOAD   = CNT_W'(LOCK_CYCLES - 1);
  localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYCLES - 1);

  localparam logic [31:0] MODE_SLOW = 32'h0003_0000;
  localparam logic [31:0] MODE_NORM = 32'h0003_0001;
  localparam logic [31:0] PWR_DOWN  = 32'h0002_0002;
  localparam logic [31:0] PWR_UP    = 32'h0002_0000;
  localparam logic [31:0] PLLA_MASK = 32'h3F0F_0000;
  localparam logic [31:0] PLLB_MASK = 32'hFFFF_0000;
  localparam logic [31:0] SEL0_MASK = 32'h3FDF_0000;
  localparam logic [31:0] SEL1_MASK = 32'hF307_0000;

  localparam logic [3:0] HCLK_DIV   = 4'd2;
  localparam logic [3:0] PCLK_DIV   = 4'd4;
  localparam logic [3:0] BRIDGE_DIV = 4'd2;
  localparam logic [4:0] CORE_DIV   = 5'd1;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_ACK, S_WAIT} state_t;

  state_t            state_q;
  logic [2:0]        step_q;
  logic [1:0]        rate_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q, error_q;

  function automatic logic [1:0] lg2(input logic [3:0] d);
    lg2 = d[3] ? 2'd3 : d[2] ? 2'd2 : d[1] ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [2:0] axi_enc(input logic [3:0] d);
    case (d)
      4'd2:    axi_enc = 3'd1;
      4'd3:    axi_enc = 3'd2;
      4'd4:    axi_enc = 3'd3;
      4'd8:    axi_enc = 3'd4;
      default: axi_enc = 3'd0;
    endcase
  endfunction

  logic       rate_ok;
  logic [1:0] rate_idx;
  always_comb begin
    rate_ok  = 1'b1;
    rate_idx = 2'd0;
    if (rate_mhz == RATE_W'(1608))      rate_idx = 2'd0;
    else if (rate_mhz == RATE_W'(1008)) rate_idx = 2'd1;
    else if (rate_mhz == RATE_W'(600))  rate_idx = 2'd2;
    else                                rate_ok  = 1'b0;
  end

  logic [5:0]  nr;
  logic [15:0] nf;
  logic [3:0]  no, peri_div, axi_div;
  logic [4:0]  aclk_div;
  always_comb begin
    nr = 6'd1;
    case (rate_q)
      2'd1:    begin nf = 16'd42; no = 4'd1; peri_div = 4'd8; axi_div = 4'd3; aclk_div = 5'd3; end
      2'd2:    begin nf = 16'd50; no = 4'd2; peri_div = 4'd4; axi_div = 4'd4; aclk_div = 5'd3; end
      default: begin nf = 16'd67; no = 4'd1; peri_div = 4'd8; axi_div = 4'd4; aclk_div = 5'd4; end
    endcase
  end

  logic [31:0] plla_w, pllb_w, sel0_w, sel1_w;
  logic [1:0]  peri_code;
  assign peri_code = lg2(peri_div) - 2'd1;
  assign plla_w = PLLA_MASK | {18'd0, nr - 6'd1, 4'd0, no - 4'd1};
  assign pllb_w = PLLB_MASK | {16'd0, nf - 16'd1};
  assign sel0_w = SEL0_MASK | {18'd0, CORE_DIV - 5'd1, 1'b0, peri_code, 1'b0, aclk_div - 5'd1};
  assign sel1_w = SEL1_MASK | {16'd0, lg2(BRIDGE_DIV), lg2(PCLK_DIV), 2'd0, lg2(HCLK_DIV), 5'd0, axi_enc(axi_div)};

  always_comb begin
    case (step_q)
      3'd0:    begin wr_addr = A_MODE; wr_data = MODE_SLOW; end
      3'd1:    begin wr_addr = A_PWR;  wr_data = PWR_DOWN;  end
      3'd2:    begin wr_addr = A_PLLA; wr_data = plla_w;    end
      3'd3:    begin wr_addr = A_PLLB; wr_data = pllb_w;    end
      3'd4:    begin wr_addr = A_PWR;  wr_data = PWR_UP;    end
      3'd5:    begin wr_addr = A_SEL0; wr_data = sel0_w;    end
      3'd6:    begin wr_addr = A_SEL1; wr_data = sel1_w;    end
      default: begin wr_addr = A_MODE; wr_data = MODE_NORM; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      rate_q  <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      error_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      error_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          if (rate_ok) begin
            rate_q  <= rate_idx;
            step_q  <= '0;
            state_q <= S_ISSUE;
          end else begin
            error_q <= 1'b1;
          end
        end
        S_ISSUE: state_q <= S_ACK;
        S_ACK: if (wr_ack) begin
          if (step_q == 3'd3) begin
            cnt_q   <= LOCK_LOAD;
            state_q <= S_WAIT;
          end else if (step_q == 3'd6) begin
            cnt_q   <= SETTLE_LOAD;
            state_q <= S_WAIT;
          end else if (step_q == 3'd7) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            step_q  <= step_q + 3'd1;
            state_q <= S_ISSUE;
          end
        end
        S_WAIT: begin
          if (cnt_q == '0) begin
            step_q  <= step_q + 3'd1;
            state_q <= S_ISSUE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign wr_valid = (state_q == S_ISSUE);
  assign busy     = (state_q != S_IDLE);
  assign done     = done_q;
  assign error    = error_q;

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // R3
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !error);
  // R2
  error_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !busy && !wr_valid);
  // R12
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(rate_q) && !error);
  // R10
  wait_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT) |-> (cnt_q <= CNT_W'(MAXW - 1)));

endmodule

// File: tb/cpu_pll_retuner_test.sv
module cpu_pll_retuner_test;
  localparam int LOCK   = 20;
  localparam int SETTLE = 45;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [10:0] rate_mhz = '0;
  logic wr_ack = 1'b0;
  logic wr_valid, busy, done, error;
  logic [11:0] wr_addr;
  logic [31:0] wr_data;

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cpu_pll_retuner #(.LOCK_CYCLES(LOCK), .SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rate_mhz(rate_mhz),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .busy(busy), .done(done), .error(error));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_addr(input int i);
    logic [11:0] t [8] = '{12'h040, 12'h00C, 12'h000, 12'h004, 12'h00C, 12'h044, 12'h048, 12'h040};
    return t[i];
  endfunction

  function automatic logic [31:0] exp_data(input int rate, input int i);
    case (i)
      0: return 32'h0003_0000;
      1: return 32'h0002_0002;
      2: return (rate == 600) ? 32'h3F0F_0001 : 32'h3F0F_0000;
      3: return (rate == 1608) ? 32'hFFFF_0042 : (rate == 1008) ? 32'hFFFF_0029 : 32'hFFFF_0031;
      4: return 32'h0002_0000;
      5: return (rate == 1608) ? 32'h3FDF_0083 : (rate == 1008) ? 32'h3FDF_0082 : 32'h3FDF_0042;
      6: return (rate == 1008) ? 32'hF307_6102 : 32'hF307_6103;
      default: return 32'h0003_0001;
    endcase
  endfunction

  task automatic pulse_start(input int rate);
    rate_mhz = 11'(rate);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // R3 R4 R5 R6 R7 R8 R9 R10 R11 (and R12 when inject is set)
  task automatic run_seq(input int rate, input int lat, input bit inject, input int mid_rate);
    int ack_cyc, t, gap, exp_gap;
    @(negedge clk);
    pulse_start(rate);
    ack_cyc = cyc - 1;
    for (int i = 0; i < 8; i++) begin
      t = 0;
      while (!wr_valid && t < 200) begin
        @(negedge clk); wr_ack = 1'b0; t++;
      end
      gap = cyc - ack_cyc;
      exp_gap = (i == 4) ? LOCK + 1 : (i == 7) ? SETTLE + 1 : 1;
      check(wr_valid == 1'b1, "R3", "strobe present", wr_valid, 1);
      check(gap == exp_gap, (i == 4) ? "R9" : (i == 7) ? "R10" : "R8", "strobe gap", gap, exp_gap);
      check(wr_addr == exp_addr(i), "R3", "address", wr_addr, exp_addr(i));
      check(wr_data == exp_data(rate, i),
            (i == 0 || i == 1 || i == 4 || i == 7) ? "R4" : (i < 4) ? "R5" : (i == 5) ? "R6" : "R7",
            "data", wr_data, exp_data(rate, i));
      check(busy == 1'b1, "R11", "busy during sequence", busy, 1);
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        check(wr_valid == 1'b0, "R8", "no strobe before ack", wr_valid, 0);
        if (inject && i == 2 && k == 0) begin
          start = 1'b1; rate_mhz = 11'(mid_rate);
          @(negedge clk);
          start = 1'b0;
          check(error == 1'b0, "R12", "no error from busy start", error, 0);
        end
      end
      wr_ack = 1'b1;
      ack_cyc = cyc;
      if (i < 7) begin
        @(negedge clk); wr_ack = 1'b0;
      end
    end
    @(negedge clk); wr_ack = 1'b0;
    check(done == 1'b1, "R11", "done pulse", done, 1);
    check(busy == 1'b0, "R11", "busy low at done", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R11", "done single cycle", done, 0);
    if (inject) begin
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        check(!wr_valid && !busy && !done, "R12", "no trailing activity",
              {wr_valid, busy, done}, 0);
      end
    end
  endtask

  // R2
  task automatic bad_rate(input int rate);
    @(negedge clk);
    pulse_start(rate);
    check(error == 1'b1, "R2", "error pulse", error, 1);
    check(busy == 1'b0, "R2", "busy stays low", busy, 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(!wr_valid && !busy && !error, "R2", "no write after reject",
            {wr_valid, busy, error}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check({busy, done, error, wr_valid} == 4'b0, "R1", "reset outputs",
          {busy, done, error, wr_valid}, 0);
    run_seq(1608, 1, 0, 0);
    run_seq(1008, 3, 0, 0);
    run_seq(600, 2, 0, 0);
    bad_rate(0);
    bad_rate(1607);
    bad_rate(2047);
    run_seq(1608, 2, 1, 600);
    run_seq(1008, 1, 1, 1234);
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule